// File: doc/BRIEF.md
# Register-Mapped Reconfiguration Port Bridge

This block sits between a host register bus and the dynamic reconfiguration port of a clock-synthesis primitive. Software starts a port transaction with one write to a control word that holds the start flag, the direction, the port address and the write data. The bridge sends that transaction to the port as a single enable pulse. It holds a busy flag until the port answers. When the port answers a read, the returned data is captured in a status word, which software polls.

A second register drives two static outputs. One releases the attached core from reset. The other enables the clock primitive. If the port does not answer within a parameterised number of cycles, the transaction is abandoned. Busy then clears and a sticky error flag is raised.

The register bus has single-cycle writes and combinational reads, and a synchronous active-low reset.

Top module: `drp_bridge`

## Requirements
- R1: After reset, reads at offsets 0x40, 0x70 and 0x74 return 0. `core_release`, `prim_enable`, `drp_en` and `drp_we` are low.
- R2: A write to offset 0x40 stores bits 1:0. Bit 0 drives `core_release` and bit 1 drives `prim_enable` from the next cycle. A read at 0x40 returns those two bits with all other bits zero.
- R3: A write to offset 0x70 with bit 29 set and bit 28 clear, while idle, starts a port write. In the next cycle `drp_en` and `drp_we` are high for exactly one cycle, `drp_addr` equals word bits 22:16 and `drp_di` equals word bits 15:0. Busy (status bit 16) reads 1 from that cycle.
- R4: The same write with bit 28 set starts a port read. `drp_en` pulses for one cycle and `drp_we` stays low.
- R5: Busy stays 1 until `drp_rdy` is sampled high during the transaction. Busy reads 0 in the cycle after that.
- R6: When a read completes, `drp_do` is captured into status bits 15:0. When a write completes, those bits are left unchanged.
- R7: A control write that arrives while busy, or that has bit 29 clear, starts no transaction and changes no port output.
- R8: If `drp_rdy` has not come back after TIMEOUT cycles of busy, busy clears, status bit 17 (error) sets and status bits 15:0 keep their value. A `drp_rdy` pulse while idle changes nothing.
- R9: The error bit stays set until the next accepted control write, and it reads 0 from the cycle after that write.
- R10: Writes to any offset other than 0x40 and 0x70 have no effect, including 0x74. Reads at unmapped offsets, and at 0x70, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational on bus_addr |
| core_release | output | 1 | Core out of reset when high |
| prim_enable | output | 1 | Clock primitive enable |
| drp_en | output | 1 | Port transaction strobe |
| drp_we | output | 1 | Port write qualifier |
| drp_addr | output | DAW | Port register address |
| drp_di | output | DW | Port write data |
| drp_do | input | DW | Port read data |
| drp_rdy | input | 1 | Port completion pulse |

## Verification
The bench builds the bridge with TIMEOUT set to 16 instead of 1024. This makes an unanswered transaction expire after a few cycles, so the exact expiry cycle, the error flag and its clearing can be checked in a short run. The other parameters keep their defaults: a 7-bit port address and 16-bit port data. A modelled port answers after a programmable latency, from zero cycles up to never. This exercises both completion in the strobe cycle and stretched busy windows, during which a second request is rejected.

// File: rtl/drp_bridge.sv
module drp_bridge #(
  parameter int AW      = 8,
  parameter int DAW     = 7,
  parameter int DW      = 16,
  parameter int TIMEOUT = 1024
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic           core_release,
  output logic           prim_enable,
  output logic           drp_en,
  output logic           drp_we,
  output logic [DAW-1:0] drp_addr,
  output logic [DW-1:0]  drp_di,
  input  logic [DW-1:0]  drp_do,
  input  logic           drp_rdy
);
  localparam logic [AW-1:0] OFS_RST  = AW'(8'h40);
  localparam logic [AW-1:0] OFS_CTRL = AW'(8'h70);
  localparam logic [AW-1:0] OFS_STAT = AW'(8'h74);
  localparam int BIT_GO   = 29;
  localparam int BIT_RD   = 28;
  localparam int BIT_ADDR = 16;
  localparam int CW       = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT - 1);

  logic [1:0]    rst_q;
  logic          busy_q, err_q, rd_q;
  logic [DW-1:0] data_q;
  logic [CW-1:0] cnt_q;
  logic          accept, expire;

  assign accept = bus_wr && bus_addr == OFS_CTRL && bus_wdata[BIT_GO] && !busy_q;
  assign expire = busy_q && !drp_rdy && cnt_q == CNT_LAST;

  assign core_release = rst_q[0];
  assign prim_enable  = rst_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n)
      rst_q <= '0;
    else if (bus_wr && bus_addr == OFS_RST)
      rst_q <= bus_wdata[1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drp_en   <= 1'b0;
      drp_we   <= 1'b0;
      drp_addr <= '0;
      drp_di   <= '0;
      rd_q     <= 1'b0;
    end else if (accept) begin
      drp_en   <= 1'b1;
      drp_we   <= !bus_wdata[BIT_RD];
      drp_addr <= bus_wdata[BIT_ADDR +: DAW];
      drp_di   <= bus_wdata[0 +: DW];
      rd_q     <= bus_wdata[BIT_RD];
    end else begin
      drp_en   <= 1'b0;
      drp_we   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      data_q <= '0;
      cnt_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      err_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (drp_rdy) begin
        busy_q <= 1'b0;
        if (rd_q) data_q <= drp_do;
      end else if (expire) begin
        busy_q <= 1'b0;
        err_q  <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_RST:  bus_rdata[1:0] = rst_q;
      OFS_STAT: begin
        bus_rdata[0 +: DW] = data_q;
        bus_rdata[16]      = busy_q;
        bus_rdata[17]      = err_q;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/drp_bridge_chk.sv
module drp_bridge_chk #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic          drp_en,
  input logic          drp_we,
  input logic          drp_rdy,
  input logic          busy_q,
  input logic          err_q,
  input logic          rd_q,
  input logic [DW-1:0] data_q
);
  localparam logic [AW-1:0] OFS_CTRL = AW'(8'h70);

  // R3
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drp_en |=> !drp_en);

  // R3
  strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drp_en |-> busy_q);

  // R4
  we_with_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drp_we |-> drp_en);

  // R5
  rdy_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && drp_rdy) |=> !busy_q);

  // R7
  no_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_CTRL && busy_q) |=> !drp_en);

  // R8
  err_on_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $fell(busy_q));

  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q && drp_rdy && rd_q) |=> $stable(data_q));
endmodule

bind drp_bridge drp_bridge_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/drp_bridge_test.sv
module drp_bridge_test;
  localparam int AW = 8, DAW = 7, DW = 16, TMO = 16;

  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic core_release, prim_enable, drp_en, drp_we;
  logic [DAW-1:0] drp_addr;
  logic [DW-1:0] drp_di, drp_do = '0;
  logic drp_rdy = 0;

  int checks = 0, errors = 0;
  int rsp_lat = 0;
  logic [23:0] expq[$];
  logic prev_en = 0;

  always #4 clk = ~clk;

  drp_bridge #(.AW(AW), .DAW(DAW), .DW(DW), .TIMEOUT(TMO)) uut (.*);

  function automatic logic [15:0] resp(input logic [6:0] a);
    return {2'b10, a, a ^ 7'h2a};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic start(input bit is_rd, input logic [6:0] a, input logic [15:0] d);
    expq.push_back({~is_rd, a, d});
    wr(8'h70, (32'd1 << 29) | (32'(is_rd) << 28) | (32'(a) << 16) | 32'(d));
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 200; i++) begin
      rd(8'h74, s);
      if (!s[16]) return;
      @(negedge clk);
    end
    check("R5 idle", 1, 0);
  endtask

  // monitor: compare port strobes with the expected queue
  initial forever begin
    @(negedge clk);
    if (drp_en) begin
      check("R3 single strobe", prev_en, 0);
      if (expq.size() == 0) check("R7 unexpected strobe", 1, 0);
      else begin
        logic [23:0] e;
        e = expq.pop_front();
        check("R3/R4 port fields", {drp_we, drp_addr, drp_di}, e);
      end
    end else check("R4 we without en", drp_we, 0);
    prev_en = drp_en;
  end

  // port model
  initial forever begin
    @(negedge clk);
    if (drp_en && rsp_lat >= 0) begin
      logic [6:0] a;
      a = drp_addr;
      repeat (rsp_lat) @(negedge clk);
      drp_do = resp(a); drp_rdy = 1;
      @(negedge clk);
      drp_rdy = 0; drp_do = 16'hdead;
    end
  end

  initial begin
    #(8 * 20000);
    check("watchdog", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] s;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(8'h40, s); check("R1 rst reg", s, 0);
    rd(8'h70, s); check("R1 ctrl", s, 0);
    rd(8'h74, s); check("R1 status", s, 0);
    check("R1 outputs", {core_release, prim_enable, drp_en, drp_we}, 0);

    wr(8'h40, 32'h3);
    check("R2 both set", {core_release, prim_enable}, 2'b11);
    wr(8'h40, 32'h1);
    check("R2 prim off core on", {core_release, prim_enable}, 2'b10);
    wr(8'h40, 32'hffff_fffe);
    rd(8'h40, s); check("R2 readback", s, 32'h2);

    rsp_lat = 3;
    start(0, 7'h15, 16'h1234);
    rd(8'h74, s); check("R3 busy set", s[16], 1);
    wait_idle();
    rd(8'h74, s); check("R6 write keeps data", s, 0);

    rsp_lat = 0;
    start(1, 7'h4e, 16'hffff);
    wait_idle();
    rd(8'h74, s); check("R6 read data", s, {16'h0, resp(7'h4e)});

    rsp_lat = 5;
    start(1, 7'h08, 16'h0);
    wr(8'h70, (32'd3 << 28) | (32'h09 << 16));
    rd(8'h74, s); check("R5 still busy", s[16], 1);
    wait_idle();
    rd(8'h74, s); check("R7 ignored while busy", s[15:0], resp(7'h08));

    wr(8'h70, (32'd1 << 28) | (32'h11 << 16));
    @(negedge clk);
    rd(8'h74, s); check("R7 no start bit", s, {16'h0, resp(7'h08)});

    rsp_lat = -1;
    start(1, 7'h10, 16'h0);
    begin
      int n = 0;
      rd(8'h74, s);
      while (s[16] && n < 100) begin @(negedge clk); n++; rd(8'h74, s); end
      check("R8 expiry cycles", n, TMO);
    end
    rd(8'h74, s); check("R8 err and data", s, {14'h0, 2'b10, resp(7'h08)});
    drp_do = 16'h5555; drp_rdy = 1;
    @(negedge clk); drp_rdy = 0;
    rd(8'h74, s); check("R8 idle rdy ignored", s, {14'h0, 2'b10, resp(7'h08)});

    rsp_lat = 2;
    start(0, 7'h20, 16'habcd);
    rd(8'h74, s); check("R9 err cleared", s[17], 0);
    wait_idle();

    wr(8'h50, 32'hffff_ffff);
    rd(8'h50, s); check("R10 unmapped read", s, 0);
    wr(8'h74, 32'h3000_1111);
    @(negedge clk);
    rd(8'h74, s); check("R10 status not writable", s, {16'h0, resp(7'h08)});
    rd(8'h70, s); check("R10 ctrl reads zero", s, 0);
    check("R2 unaffected", {core_release, prim_enable}, 2'b01);

    repeat (4) @(negedge clk);
    check("R7 queue drained", expq.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule